// File: doc/BRIEF.md
# Outbound Bus-Master Request Sequencer

This block carries transactions from an internal fabric out onto a shared parallel address/data bus on which it acts as an initiator. The internal side hands over a request header (address, address space, direction and beat count). A write then streams its data beats into a local burst buffer, and a read waits for its data to come back from the bus. The block asks for the bus at a point that depends on the direction. A write asks only after its whole burst has been handed over. A read asks as soon as its address space decodes as external. A request to a non-external space is retired without touching the bus.

When the request is granted, the block spends one cycle in the address phase, driving the 32-bit start address and a 4-bit bus command. It then runs the data phase beat by beat, paced by the target's ready input. If the target disconnects part-way through a burst, the block drops out of the data phase and asks for the bus again. It re-enters with the address advanced past the beats already taken, and it continues the same burst from the first beat not yet accepted. Holding a pending write does not depend on other bus traffic: nothing outside the grant moves it. A one-cycle done pulse tells the internal side that the request has retired.

Top module: `obm_sequencer`

## Requirements
- R1: For a write, `bus_req` stays low while data beats are still being handed over and rises in the cycle after the final beat (`wd_valid` with `wd_ready`) is taken.
- R2: For a read whose space code is 0 to 4, `bus_req` is high in the cycle after the header is accepted.
- R3: A request with space code 5, 6 or 7 never raises `bus_req`, `addr_phase` or `dat_phase`, and `done` pulses in the cycle after acceptance.
- R4: If `bus_gnt` is high while `bus_req` is high, then in the next cycle `addr_phase` is high for exactly one cycle, `bus_req` is low in that same cycle, and `bus_ad` and `bus_cmd` carry the address and command.
- R5: Command codes depend on the space code and the direction. Space 0 (memory) gives 0110 for a read and 0111 for a write. Space 1 (I/O) gives 0010 / 0011. Space 2 (configuration) gives 1010 / 1011. Space 3 (special cycle) always gives 0001. Space 4 (interrupt acknowledge) always gives 0000.
- R6: The data phase follows the address phase directly. Write beats appear on `bus_wdata` in order and are held while `tgt_ready` is low. A request with `in_len` = n moves n+1 beats.
- R7: `tgt_disc` in a data cycle that is not the final accepted beat ends the data phase, and `bus_req` rises in the next cycle. The current beat counts as taken only if `tgt_ready` was also high. After the next grant the address is the start address plus 4 times the beats taken, and data resumes at the first beat not taken.
- R8: Bursts of up to `MAX_BEATS` (8) beats are buffered. `in_ready` is low from the cycle after a header is accepted until the request has retired.
- R9: `done` is a one-cycle pulse in the cycle after the final beat is accepted, and `in_ready` is high in the cycle after `done`.
- R10: During a read data phase, `rd_valid` equals `tgt_ready` and `rd_data` equals `bus_rdata`.
- R11: After reset, `in_ready` is high and `bus_req`, `addr_phase`, `dat_phase`, `done`, `wd_ready` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request header present |
| in_ready | output | 1 | Block idle and able to take a header |
| in_write | input | 1 | 1 = write, 0 = read |
| in_space | input | 3 | Address space code (0..4 external, 5..7 local) |
| in_addr | input | 32 | Start address |
| in_len | input | 3 | Beats minus one |
| wd_valid | input | 1 | Write data beat present |
| wd_ready | output | 1 | Block is collecting write beats |
| wd_data | input | 32 | Write data beat |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | 32 | Read beat data |
| done | output | 1 | Request retired (one-cycle pulse) |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| addr_phase | output | 1 | Address phase in progress |
| bus_ad | output | 32 | Address during the address phase |
| bus_cmd | output | 4 | Bus command during the address phase |
| dat_phase | output | 1 | Data phase in progress |
| bus_wdata | output | 32 | Write data during the data phase |
| bus_rdata | input | 32 | Read data from the target |
| tgt_ready | input | 1 | Target takes or supplies the current beat |
| tgt_disc | input | 1 | Target disconnect |

## Verification
The bench builds the block with its defaults: 32-bit address and data, and an 8-beat buffer. With those values it can reach every burst length from 1 to 8 and every point at which a write burst can be disconnected, both with the current beat taken and with it refused. The small space-code field lets it try all eight codes in both directions. The expected addresses and data words are computed arithmetically from the start address, the beat index and a per-test tag.

// File: rtl/obm_pkg.sv
package obm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_REQ  = 3'd2,
    ST_ADDR = 3'd3,
    ST_DATA = 3'd4,
    ST_FIN  = 3'd5
  } obm_state_e;

  localparam logic [3:0] CMD_INTACK = 4'b0000;
  localparam logic [3:0] CMD_SPECL  = 4'b0001;
  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;
endpackage

// File: rtl/obm_rst_sync.sv
module obm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/obm_cmd_map.sv
module obm_cmd_map
  import obm_pkg::*;
(
  input  logic [2:0] space,
  input  logic       write,
  output logic [3:0] cmd,
  output logic       ext
);
  always_comb begin
    ext = 1'b1;
    cmd = CMD_MEM_RD;
    case (space)
      3'd0: cmd = write ? CMD_MEM_WR : CMD_MEM_RD;
      3'd1: cmd = write ? CMD_IO_WR  : CMD_IO_RD;
      3'd2: cmd = write ? CMD_CFG_WR : CMD_CFG_RD;
      3'd3: cmd = CMD_SPECL;
      3'd4: cmd = CMD_INTACK;
      default: ext = 1'b0;
    endcase
  end
endmodule

// File: rtl/obm_wbuf.sv
module obm_wbuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk) begin
      if (ent_en) mem[gi] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/obm_ctrl.sv
module obm_ctrl
  import obm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BEATS = 8,
  localparam int IDX_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic              in_ext,
  input  logic [3:0]        in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [IDX_W-1:0]  in_len,
  input  logic              wd_valid,
  input  logic              bus_gnt,
  input  logic              tgt_ready,
  input  logic              tgt_disc,
  output logic              in_ready,
  output logic              wd_ready,
  output logic              buf_we,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              is_write,
  output logic              bus_req,
  output logic              addr_phase,
  output logic [ADDR_W-1:0] bus_ad,
  output logic [3:0]        bus_cmd,
  output logic              dat_phase,
  output logic              done
);
  obm_state_e        st_q, st_d;
  logic [IDX_W-1:0]  fill_q, fill_d, beat_q, beat_d, len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;
  logic              wr_q;
  logic              hdr_en, fill_en, beat_en;

  // next state
  always_comb begin
    st_d    = st_q;
    fill_d  = fill_q;
    beat_d  = beat_q;
    hdr_en  = 1'b0;
    fill_en = 1'b0;
    beat_en = 1'b0;
    case (st_q)
      ST_IDLE: if (in_valid) begin
        hdr_en  = 1'b1;
        fill_en = 1'b1;
        beat_en = 1'b1;
        fill_d  = '0;
        beat_d  = '0;
        if (!in_ext)       st_d = ST_FIN;
        else if (in_write) st_d = ST_FILL;
        else               st_d = ST_REQ;
      end
      ST_FILL: if (wd_valid) begin
        fill_en = 1'b1;
        fill_d  = fill_q + 1'b1;
        if (fill_q == len_q) st_d = ST_REQ;
      end
      ST_REQ:  if (bus_gnt) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (tgt_ready) begin
          if (beat_q == len_q) st_d = ST_FIN;
          else begin
            beat_en = 1'b1;
            beat_d  = beat_q + 1'b1;
            if (tgt_disc) st_d = ST_REQ;
          end
        end else if (tgt_disc) begin
          st_d = ST_REQ;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      fill_q <= '0;
      beat_q <= '0;
      len_q  <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (fill_en) fill_q <= fill_d;
      if (beat_en) beat_q <= beat_d;
      if (hdr_en) begin
        len_q  <= in_len;
        addr_q <= in_addr;
        cmd_q  <= in_cmd;
        wr_q   <= in_write;
      end
    end
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign wd_ready   = (st_q == ST_FILL);
  assign buf_we     = wd_ready && wd_valid;
  assign fill_idx   = fill_q;
  assign beat_idx   = beat_q;
  assign is_write   = wr_q;
  assign bus_req    = (st_q == ST_REQ);
  assign addr_phase = (st_q == ST_ADDR);
  assign dat_phase  = (st_q == ST_DATA);
  assign done       = (st_q == ST_FIN);
  assign bus_cmd    = addr_phase ? cmd_q : 4'b0000;
  assign bus_ad     = addr_phase
                    ? addr_q + {{(ADDR_W-IDX_W-2){1'b0}}, beat_q, 2'b00}
                    : '0;

  assert_gnt_to_addr_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_req && bus_gnt) |=> (addr_phase && !bus_req));

  assert_addr_then_data_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    addr_phase |=> (dat_phase && !addr_phase));

  assert_read_req_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_ready && !in_write && in_ext) |=> bus_req);

  assert_write_req_after_fill_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(bus_req) && wr_q && !$past(dat_phase)) |-> $past(wd_valid && wd_ready));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> (!done && in_ready));

  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({bus_req, addr_phase, dat_phase, done, wd_ready}));
endmodule

// File: rtl/obm_sequencer.sv
module obm_sequencer
  import obm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 8,
  localparam int IDX_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [2:0]        in_space,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [IDX_W-1:0]  in_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              addr_phase,
  output logic [ADDR_W-1:0] bus_ad,
  output logic [3:0]        bus_cmd,
  output logic              dat_phase,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              tgt_ready,
  input  logic              tgt_disc
);
  logic              rst_sn;
  logic [3:0]        dec_cmd;
  logic              dec_ext;
  logic              buf_we, is_write;
  logic [IDX_W-1:0]  fill_idx, beat_idx;
  logic [DATA_W-1:0] buf_rd;

  obm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  obm_cmd_map u_map (
    .space (in_space),
    .write (in_write),
    .cmd   (dec_cmd),
    .ext   (dec_ext)
  );

  obm_wbuf #(.DATA_W(DATA_W), .DEPTH(MAX_BEATS)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (fill_idx),
    .wr_data (wd_data),
    .rd_idx  (beat_idx),
    .rd_data (buf_rd)
  );

  obm_ctrl #(.ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .in_valid   (in_valid),
    .in_write   (in_write),
    .in_ext     (dec_ext),
    .in_cmd     (dec_cmd),
    .in_addr    (in_addr),
    .in_len     (in_len),
    .wd_valid   (wd_valid),
    .bus_gnt    (bus_gnt),
    .tgt_ready  (tgt_ready),
    .tgt_disc   (tgt_disc),
    .in_ready   (in_ready),
    .wd_ready   (wd_ready),
    .buf_we     (buf_we),
    .fill_idx   (fill_idx),
    .beat_idx   (beat_idx),
    .is_write   (is_write),
    .bus_req    (bus_req),
    .addr_phase (addr_phase),
    .bus_ad     (bus_ad),
    .bus_cmd    (bus_cmd),
    .dat_phase  (dat_phase),
    .done       (done)
  );

  assign bus_wdata = (dat_phase && is_write) ? buf_rd : '0;
  assign rd_valid  = dat_phase && !is_write && tgt_ready;
  assign rd_data   = rd_valid ? bus_rdata : '0;

  assert_rd_mirror_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_valid |-> (dat_phase && tgt_ready && rd_data == bus_rdata));
endmodule

// File: tb/obm_sequencer_tb_top.sv
module obm_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_write, wd_valid, bus_gnt, tgt_ready, tgt_disc;
  logic [2:0]  in_space, in_len;
  logic [31:0] in_addr, wd_data, bus_rdata;
  logic        in_ready, wd_ready, rd_valid, done, bus_req, addr_phase, dat_phase;
  logic [31:0] rd_data, bus_ad, bus_wdata;
  logic [3:0]  bus_cmd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  obm_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_space(in_space), .in_addr(in_addr), .in_len(in_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .addr_phase(addr_phase),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .dat_phase(dat_phase),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tgt_ready(tgt_ready), .tgt_disc(tgt_disc)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int tag, input int i);
    return 32'hA500_0000 + 32'(tag * 256 + i);
  endfunction

  function automatic logic [3:0] exp_cmd(input int sp, input logic wr);
    case (sp)
      0: return wr ? 4'b0111 : 4'b0110;
      1: return wr ? 4'b0011 : 4'b0010;
      2: return wr ? 4'b1011 : 4'b1010;
      3: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Grant, address phase and data phase; returns at the negedge after done.
  // disc_at > 0: disconnect after disc_at beats; nr = refuse that beat instead.
  task automatic serve(input int tag, input int sp, input logic wr,
                       input logic [31:0] base, input int len,
                       input int disc_at, input logic nr, input logic stall);
    int  b = 0;
    bit  fin = 0;
    bit  disc_used = 0;
    while (!fin) begin
      chk(bus_req === 1'b1, "R1/R2/R7 bus_req before grant", 32'(bus_req), 1);
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      chk(addr_phase === 1'b1 && bus_req === 1'b0, "R4 addr phase, req low",
          {30'd0, addr_phase, bus_req}, 32'd2);
      chk(bus_ad === base + 32'(4 * b), "R4/R7 address", bus_ad, base + 32'(4 * b));
      chk(bus_cmd === exp_cmd(sp, wr), "R5 command", 32'(bus_cmd), 32'(exp_cmd(sp, wr)));
      @(negedge clk);
      chk(addr_phase === 1'b0, "R4 addr phase one cycle", 32'(addr_phase), 0);
      forever begin
        chk(dat_phase === 1'b1, "R6 data phase", 32'(dat_phase), 1);
        if (wr) chk(bus_wdata === pat(tag, b), "R6 write beat", bus_wdata, pat(tag, b));
        if (stall && b == 1) begin
          tgt_ready = 1'b0;
          @(negedge clk);
          chk(dat_phase === 1'b1 && (!wr || bus_wdata === pat(tag, b)),
              "R6 beat held on stall", bus_wdata, pat(tag, b));
        end
        if (!disc_used && disc_at > 0 && b + 1 == disc_at && b < len) begin
          disc_used = 1;
          tgt_disc  = 1'b1;
          tgt_ready = !nr;
          @(negedge clk);
          tgt_disc  = 1'b0;
          tgt_ready = 1'b0;
          if (!nr) b++;
          chk(bus_req === 1'b1 && dat_phase === 1'b0, "R7 release and request",
              {30'd0, bus_req, dat_phase}, 32'd2);
          break;
        end
        tgt_ready = 1'b1;
        bus_rdata = pat(tag, b);
        #1;
        if (!wr) begin
          chk(rd_valid === 1'b1, "R10 rd_valid", 32'(rd_valid), 1);
          chk(rd_data === pat(tag, b), "R10 rd_data", rd_data, pat(tag, b));
        end
        @(negedge clk);
        tgt_ready = 1'b0;
        if (b == len) begin
          chk(done === 1'b1, "R9 done pulse", 32'(done), 1);
          chk(dat_phase === 1'b0, "R6 beat count", 32'(dat_phase), 0);
          fin = 1;
          break;
        end
        chk(done === 1'b0, "R9 no early done", 32'(done), 0);
        b++;
      end
    end
    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R9 done one cycle then idle",
        {30'd0, done, in_ready}, 32'd1);
  endtask

  task automatic do_write(input int tag, input int sp, input logic [31:0] base,
                          input int len, input int disc_at, input logic nr,
                          input logic stall);
    in_valid = 1'b1; in_write = 1'b1; in_space = 3'(sp);
    in_addr = base; in_len = 3'(len);
    chk(in_ready === 1'b1, "R8 in_ready idle", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      wd_valid = 1'b1;
      wd_data  = pat(tag, i);
      chk(bus_req === 1'b0, "R1 no request while filling", 32'(bus_req), 0);
      chk(wd_ready === 1'b1 && in_ready === 1'b0, "R8 fill, new requests held off",
          {30'd0, wd_ready, in_ready}, 32'd2);
      @(negedge clk);
    end
    wd_valid = 1'b0;
    chk(bus_req === 1'b1, "R1 request after last beat", 32'(bus_req), 1);
    serve(tag, sp, 1'b1, base, len, disc_at, nr, stall);
  endtask

  task automatic do_read(input int tag, input int sp, input logic [31:0] base,
                         input int len);
    in_valid = 1'b1; in_write = 1'b0; in_space = 3'(sp);
    in_addr = base; in_len = 3'(len);
    @(negedge clk);
    in_valid = 1'b0;
    chk(bus_req === 1'b1, "R2 read request immediately", 32'(bus_req), 1);
    chk(in_ready === 1'b0, "R8 held off during read", 32'(in_ready), 0);
    serve(tag, sp, 1'b0, base, len, 0, 1'b0, 1'b0);
  endtask

  task automatic do_local(input int sp, input logic wr);
    in_valid = 1'b1; in_write = wr; in_space = 3'(sp);
    in_addr = 32'h1234_5678; in_len = 3'd3;
    @(negedge clk);
    in_valid = 1'b0;
    chk(done === 1'b1, "R3 local done", 32'(done), 1);
    chk(bus_req === 1'b0 && wd_ready === 1'b0, "R3 no bus activity",
        {30'd0, bus_req, wd_ready}, 0);
    @(negedge clk);
    chk(bus_req === 1'b0 && addr_phase === 1'b0 && dat_phase === 1'b0 && in_ready === 1'b1,
        "R3 stays idle", {28'd0, bus_req, addr_phase, dat_phase, in_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_write = 0; in_space = 0; in_addr = 0; in_len = 0;
    wd_valid = 0; wd_data = 0; bus_gnt = 0; tgt_ready = 0; tgt_disc = 0;
    bus_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready === 1'b1, "R11 in_ready after reset", 32'(in_ready), 1);
    chk({bus_req, addr_phase, dat_phase, done, wd_ready, rd_valid} === 6'b0,
        "R11 outputs low after reset",
        {26'd0, bus_req, addr_phase, dat_phase, done, wd_ready, rd_valid}, 0);

    // R1 R6 R8 R9: every write length, memory space
    for (int len = 0; len < 8; len++)
      do_write(len, 0, 32'h4000_0000 + 32'(len * 64), len, 0, 1'b0, 1'b0);
    // R6 stall while tgt_ready low
    do_write(20, 1, 32'h0000_0100, 3, 0, 1'b0, 1'b1);
    // R7 every disconnect point, beat taken and beat refused
    for (int len = 1; len < 8; len++)
      for (int k = 1; k <= len; k++) begin
        do_write(100 + len * 8 + k, 0, 32'h8000_0000 + 32'(len * 256), len, k, 1'b0, 1'b0);
        do_write(200 + len * 8 + k, 2, 32'h9000_0000 + 32'(len * 256), len, k, 1'b1, 1'b0);
      end
    // R5 every external space in both directions
    for (int sp = 0; sp < 5; sp++) begin
      do_write(40 + sp, sp, 32'h0000_2000 + 32'(sp * 16), 0, 0, 1'b0, 1'b0);
      do_read(50 + sp, sp, 32'h0000_3000 + 32'(sp * 16), 0);
    end
    // R2 R10 read bursts
    for (int len = 1; len < 8; len++)
      do_read(60 + len, 0, 32'hC000_0000 + 32'(len * 128), len);
    // R3 local spaces
    for (int sp = 5; sp < 8; sp++) begin
      do_local(sp, 1'b0);
      do_local(sp, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule